// File: doc/BRIEF.md
# Cascaded First-Word-Fall-Through FIFO Chain

This block builds one deep FIFO from a row of small self-timed stages. Each stage presents its oldest word at its output as soon as it holds one, with no read needed to fetch it. The stage's output-ready flag then drives the write request of the next stage. That next stage's input-ready flag lets the word leave the stage before it. Words therefore move toward the read end without any outside control, and free slots move back toward the write end one stage per clock. All stages, and the transfers between them, run on one clock.

The write side and the read side are streams with active-low readiness. A word is taken when `wr_en` is high and `in_rdy_n` is low. A word is consumed when `rd_en` is high and `out_rdy_n` is low. While `out_rdy_n` is low and no read is made, the read side holds back: `dout` keeps its value. If `in_rdy_n` is high, a write request is refused and nothing changes. If `out_rdy_n` is high, a read request is refused and nothing changes. Both flags come straight from registers, so a request never loops back into the same cycle's flags.

Top module: `fifo_chain`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `out_rdy_n` is high and `in_rdy_n` is low: every stage is empty.
- R2: While `out_rdy_n` is low, `dout` shows the oldest word not yet read, with no read request needed to bring it forward.
- R3: Words leave in the exact order they were accepted.
- R4: A write request made while `in_rdy_n` is high is refused: that word never appears at the output, and no other word is lost or duplicated.
- R5: A read request made while `out_rdy_n` is high is refused. The chain stays empty, and the next word written is the next word read.
- R6: The chain holds exactly NSTAGE × DEPTH words. `in_rdy_n` is low whenever fewer words are held once the chain has settled, and it is never low when that many are held.
- R7: A word written at clock edge 0 into an empty chain drives `out_rdy_n` low after edge 3·(NSTAGE−1)+2, and not after any earlier edge.
- R8: When one word is read at edge t from a full, settled chain, `in_rdy_n` stays high after edges t through t+NSTAGE−2 and goes low after edge t+NSTAGE−1, as the free slot moves back one stage per clock.
- R9: While `out_rdy_n` is low and `rd_en` is low, the next cycle still has `out_rdy_n` low and an unchanged `dout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for writes, reads and transfers between stages |
| rst | input | 1 | Synchronous reset, active high; empties every stage |
| wr_en | input | 1 | Write request |
| din | input | W (18) | Write data |
| in_rdy_n | output | 1 | Low when the first stage can take a word |
| rd_en | input | 1 | Read request |
| dout | output | W (18) | Oldest word held, valid while `out_rdy_n` is low |
| out_rdy_n | output | 1 | Low when a word is waiting at the last stage |

## Verification
On every cycle the assertions track how many words the ports have accepted and consumed. They check that the input is never ready at full capacity and that the output is never ready when the chain is empty. They also check that a waiting word stays put and steady while no read is made, and that the flags return to their reset values when reset is released. Word order, the exact first-word latency through the chain, and the backward ripple of a free slot depend on what came before, so only the bench's scenarios show them. The bench covers these with a queue model, a cold-start run, a fill and single-read run, and a long random run.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;
  localparam int unsigned WORD_W_DEF = 18;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int unsigned ptr_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/fifo_chain_ring.sv
module fifo_chain_ring
  import fifo_chain_pkg::*;
#(
  parameter int unsigned W     = WORD_W_DEF,
  parameter int unsigned DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push,
  input  logic [W-1:0]              push_data,
  input  logic                      pop,
  output logic [W-1:0]              head_data,
  output logic [cnt_w(DEPTH)-1:0]   fill
);
  localparam int unsigned PW = ptr_w(DEPTH);
  localparam int unsigned CW = cnt_w(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign head_data = mem[rp];
  assign fill      = cnt;
endmodule

// File: rtl/fifo_chain_stage.sv
module fifo_chain_stage
  import fifo_chain_pkg::*;
#(
  parameter int unsigned W     = WORD_W_DEF,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] din,
  output logic         ir_n,
  input  logic         rd_en,
  output logic [W-1:0] dout,
  output logic         or_n
);
  localparam int unsigned CW = cnt_w(DEPTH);

  logic [CW-1:0] occ, mem_fill, seen;
  logic          out_v, wr_q;
  logic [W-1:0]  out_q, head;
  logic          wr_ok, rd_ok, fetch;

  // occupancy counts the ring plus the output register
  assign ir_n  = (occ == CW'(DEPTH));
  assign or_n  = ~out_v;
  assign dout  = out_q;
  assign wr_ok = wr_en & ~ir_n;
  assign rd_ok = rd_en & out_v;

  // a word written this cycle becomes fetchable one cycle later
  assign seen  = mem_fill - CW'(wr_q);
  assign fetch = (seen != '0) && (!out_v || rd_ok);

  fifo_chain_ring #(.W(W), .DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst       (rst),
    .push      (wr_ok),
    .push_data (din),
    .pop       (fetch),
    .head_data (head),
    .fill      (mem_fill)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      occ   <= '0;
      out_v <= 1'b0;
      wr_q  <= 1'b0;
      out_q <= '0;
    end else begin
      occ  <= occ + CW'(wr_ok) - CW'(rd_ok);
      wr_q <= wr_ok;
      if (fetch) begin
        out_v <= 1'b1;
        out_q <= head;
      end else if (rd_ok) begin
        out_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fifo_chain.sv
module fifo_chain
  import fifo_chain_pkg::*;
#(
  parameter int unsigned NSTAGE = 3,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned W      = WORD_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] din,
  output logic         in_rdy_n,
  input  logic         rd_en,
  output logic [W-1:0] dout,
  output logic         out_rdy_n
);
  logic [W-1:0] lnk_d    [NSTAGE];
  logic         lnk_or_n [NSTAGE];
  logic         lnk_ir_n [NSTAGE];
  logic         st_wr    [NSTAGE];
  logic         st_rd    [NSTAGE];
  logic [W-1:0] st_din   [NSTAGE];

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign st_wr[k]  = wr_en;
      assign st_din[k] = din;
    end else begin : g_link_in
      // a waiting word upstream is a write request downstream
      assign st_wr[k]  = ~lnk_or_n[k-1];
      assign st_din[k] = lnk_d[k-1];
    end

    if (k == NSTAGE - 1) begin : g_tail
      assign st_rd[k] = rd_en;
    end else begin : g_link_out
      // downstream space releases the upstream word
      assign st_rd[k] = ~lnk_ir_n[k+1];
    end

    fifo_chain_stage #(.W(W), .DEPTH(DEPTH)) u_stage (
      .clk   (clk),
      .rst   (rst),
      .wr_en (st_wr[k]),
      .din   (st_din[k]),
      .ir_n  (lnk_ir_n[k]),
      .rd_en (st_rd[k]),
      .dout  (lnk_d[k]),
      .or_n  (lnk_or_n[k])
    );
  end

  assign in_rdy_n  = lnk_ir_n[0];
  assign out_rdy_n = lnk_or_n[NSTAGE-1];
  assign dout      = lnk_d[NSTAGE-1];
endmodule

// File: rtl/fifo_chain_chk.sv
module fifo_chain_chk
  import fifo_chain_pkg::*;
#(
  parameter int unsigned NSTAGE = 3,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned W      = WORD_W_DEF
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic [W-1:0] din,
  input logic         in_rdy_n,
  input logic         rd_en,
  input logic [W-1:0] dout,
  input logic         out_rdy_n
);
  localparam int unsigned CAP = NSTAGE * DEPTH;
  localparam int unsigned OW  = cnt_w(CAP) + 1;

  logic [OW-1:0] held;
  logic          acc_w, acc_r;
  logic [W-1:0]  din_seen;

  assign acc_w    = wr_en & ~in_rdy_n;
  assign acc_r    = rd_en & ~out_rdy_n;
  assign din_seen = din;

  always_ff @(posedge clk) begin
    if (rst) held <= '0;
    else     held <= held + OW'(acc_w) - OW'(acc_r);
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (held == OW'(CAP)) |-> in_rdy_n);

  assert_bound_R6: assert property (@(posedge clk) disable iff (rst)
    held <= OW'(CAP));

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    (held == '0) |-> out_rdy_n);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!out_rdy_n && !rd_en) |=> (!out_rdy_n && $stable(dout)));

  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (out_rdy_n && !in_rdy_n));
endmodule

bind fifo_chain fifo_chain_chk #(.NSTAGE(NSTAGE), .DEPTH(DEPTH), .W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .din       (din),
  .in_rdy_n  (in_rdy_n),
  .rd_en     (rd_en),
  .dout      (dout),
  .out_rdy_n (out_rdy_n)
);

// File: tb/fifo_chain_test.sv
module fifo_chain_test;
  localparam int NS  = 3;
  localparam int DP  = 4;
  localparam int W   = 18;
  localparam int CAP = NS * DP;
  localparam int LAT = 3 * (NS - 1) + 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [W-1:0] din = '0;
  logic         rd_en = 1'b0;
  logic         in_rdy_n, out_rdy_n;
  logic [W-1:0] dout;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int nxt   = 1;
  logic [W-1:0] q[$];

  always #5 clk = ~clk;

  fifo_chain #(.NSTAGE(NS), .DEPTH(DP), .W(W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .din(din), .in_rdy_n(in_rdy_n),
    .rd_en(rd_en), .dout(dout), .out_rdy_n(out_rdy_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, model the edge, return at next negedge
  task automatic cyc(input bit w, input logic [W-1:0] d, input bit r);
    bit aw, ar;
    wr_en = w; din = d; rd_en = r;
    aw = w && !in_rdy_n;
    ar = r && !out_rdy_n;
    if (q.size() == 0) chk(out_rdy_n === 1'b1, "R5 empty flag", out_rdy_n, 1);
    if (q.size() == CAP) chk(in_rdy_n === 1'b1, "R6 full flag", in_rdy_n, 1);
    if (!out_rdy_n) begin
      if (q.size() == 0) chk(1'b0, "R2 word with empty model", int'(dout), -1);
      else chk(dout === q[0], "R3 order/R2 head", int'(dout), int'(q[0]));
    end
    if (ar && q.size() > 0) void'(q.pop_front());
    if (aw) q.push_back(d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  function automatic logic [W-1:0] fresh();
    nxt++;
    return W'(nxt * 37 + 5);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] first, held_v;
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(out_rdy_n === 1'b1, "R1 out_rdy_n", out_rdy_n, 1);
    chk(in_rdy_n === 1'b0, "R1 in_rdy_n", in_rdy_n, 0);

    // R7 cold-start latency
    first = fresh();
    cyc(1, first, 0);
    for (int k = 0; k < LAT; k++) begin
      chk(out_rdy_n === 1'b1, "R7 early", out_rdy_n, 1);
      cyc(0, '0, 0);
    end
    chk(out_rdy_n === 1'b0, "R7 on time", out_rdy_n, 0);
    chk(dout === first, "R7 data", int'(dout), int'(first));
    cyc(0, '0, 1);

    // R5 reads on empty chain ignored
    for (int k = 0; k < 4; k++) cyc(0, '0, 1);
    chk(out_rdy_n === 1'b1, "R5 still empty", out_rdy_n, 1);
    first = fresh();
    cyc(1, first, 0);
    for (int k = 0; k < 40 && out_rdy_n; k++) cyc(0, '0, 0);
    chk(dout === first, "R5 next word", int'(dout), int'(first));
    cyc(0, '0, 1);

    // R9 / R2 hold without reads
    for (int k = 0; k < 3; k++) cyc(1, fresh(), 0);
    for (int k = 0; k < 40 && out_rdy_n; k++) cyc(0, '0, 0);
    held_v = dout;
    for (int k = 0; k < 6; k++) begin
      cyc(0, '0, 0);
      chk(!out_rdy_n && dout === held_v, "R9 hold", int'(dout), int'(held_v));
    end
    for (int k = 0; k < 60 && q.size() > 0; k++) cyc(0, '0, 1);

    // R6 fill to capacity
    for (int k = 0; k < 400 && q.size() < CAP; k++) cyc(1, fresh(), 0);
    chk(q.size() == CAP, "R6 accepted count", q.size(), CAP);
    for (int k = 0; k < 4 * NS + DP; k++) cyc(0, '0, 0);
    chk(in_rdy_n === 1'b1, "R6 full after settle", in_rdy_n, 1);
    // R4 refused writes
    for (int k = 0; k < 3; k++) cyc(1, W'(18'h3ABCD), 0);
    chk(q.size() == CAP, "R4 refused", q.size(), CAP);

    // R8 free slot ripple
    cyc(0, '0, 1);
    for (int k = 0; k < NS - 1; k++) begin
      chk(in_rdy_n === 1'b1, "R8 early", in_rdy_n, 1);
      cyc(0, '0, 0);
    end
    chk(in_rdy_n === 1'b0, "R8 on time", in_rdy_n, 0);

    // drain, R3 and R4 (refused word never seen)
    for (int k = 0; k < 200 && q.size() > 0; k++) begin
      if (!out_rdy_n) chk(dout !== W'(18'h3ABCD), "R4 refused word", int'(dout), 0);
      cyc(0, '0, 1);
    end
    chk(q.size() == 0, "R3 drained", q.size(), 0);

    // random streaming, R3
    for (int k = 0; k < 3000; k++)
      cyc(($urandom % 4) != 0, fresh(), ($urandom % 3) != 0);
    for (int k = 0; k < 300 && q.size() > 0; k++) cyc(0, '0, 1);
    chk(q.size() == 0 && out_rdy_n === 1'b1, "R3 final drain", q.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule